// File: doc/BRIEF.md
# Serial EEPROM Instruction Front End with Write Protection

This block sits between a mode-0 SPI slave pin set and a 1024-byte byte array. It decodes one-byte opcodes and keeps a write enable latch. It also holds a five-bit configuration field made of a two-bit watchdog period code and a three-bit block lock code, and it runs a timed write cycle that stands in for the nonvolatile programming delay. The SPI pins are synchronized to the system clock, so the serial clock must run well below the system clock (at least four system clocks per half period).

A host sends WREN before each page write or configuration write. The lock code then decides which of seven regions refuse array writes. Reads are never refused. While a write cycle runs, only the status read is served, and the status byte flags the cycle in its top bit. The configuration field is cleared only by the power-on reset; the ordinary reset leaves it untouched.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Opcode 0x06 sets the write enable latch and opcode 0x04 clears it. A page write sent after 0x06 changes the array; one sent after 0x04 does not.
- R2: A page write (0x02) or configuration write (0x01) is discarded when the latch is clear at the moment its opcode is received. No write cycle starts, and neither the array nor the status changes.
- R3: The latch is cleared by either reset and at the end of every completed write cycle. A following write that is not preceded by 0x06 has no effect.
- R4: Opcode 0x05 returns the status byte {busy, 0, 0, wd[1:0], lock[2:0]}, with busy in bit 7. After power-on reset the byte reads 0x18.
- R5: The status byte can be read during a write cycle, and it then reads with bit 7 set. Each further byte clocked within the same select returns a fresh copy of the status byte.
- R6: The lock code protects this address range: 0 nothing; 1 0x000-0x0FF; 2 0x100-0x1FF; 3 0x200-0x2FF; 4 0x300-0x3FF; 5 0x000-0x1FF; 6 0x000-0x00F; 7 0x3F0-0x3FF.
- R7: Protected bytes still read back their stored value. A configuration write (0x01 then one byte, whose bits 4:0 become {wd, lock}) takes effect at the end of its write cycle and holds until the next one.
- R8: An address is two bytes, sent high byte first. Bits 15:10 are ignored.
- R9: A page write takes up to 16 data bytes. The address wraps inside its 16-byte page, and data bytes after the 16th are dropped.
- R10: A write cycle starts only when select rises after a whole number of bytes, with at least one data byte (page write) or the configuration byte. If select rises part-way through a byte, the command is abandoned.
- R11: A read (0x03) returns bytes MSB first from the given address. The address increments through the whole array and wraps from 0x3FF to 0x000.
- R12: A write cycle lasts WRITE_CYCLES clocks. Any opcode other than 0x05 that arrives during the cycle is ignored.
- R13: miso_oe is low while select is high. Output bits change after falling serial clock edges, and input bits are taken on rising edges.
- R14: The watchdog and lock bits survive rst_n. Only por_n returns them to 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | Logic reset, active low, keeps the configuration field |
| cs_n | input | 1 | SPI select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | SPI data in |
| miso | output | 1 | SPI data out |
| miso_oe | output | 1 | High when miso should be driven onto the pad |

## Verification
The status read and the timed write cycle share the same cycles. A page write is deselected and a status read is issued straight away, so the busy bit is sampled while the array is being programmed. A second page write is then sent inside the same cycle, with the latch still set. The status byte must read with bit 7 set and the old configuration bits. Once the cycle ends, the second write's target must still hold its earlier value.

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 200
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WRITE_CYCLES + 1);
  localparam int PN_W  = ADDR_W - PAGE_W;

  typedef enum logic [2:0] {S_OP, S_AH, S_AL, S_WR, S_RD, S_SR, S_RS, S_SKIP} st_t;

  logic rst_all_n;
  assign rst_all_n = por_n & rst_n;

  logic [2:0] cs_q, sck_q;
  logic [1:0] din_q;
  logic [2:0] bitcnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh, rx_byte, status, rdata;
  st_t st;
  logic is_rd, load_pend, wel, sr_pend;
  logic [ADDR_W-1:0] addr, waddr;
  logic [PAGE_W:0] nbytes;
  logic [PAGE-1:0] vmask;
  logic [4:0] stat, sr_new;
  logic busy, wphase, kind_sr;
  logic [TW-1:0] timer;
  logic [PAGE_W-1:0] widx;
  logic [PN_W-1:0] wpage;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];

  function automatic logic locked(input logic [ADDR_W-1:0] a, input logic [2:0] b);
    case (b)
      3'd1: return a[ADDR_W-1 -: 2] == 2'd0;
      3'd2: return a[ADDR_W-1 -: 2] == 2'd1;
      3'd3: return a[ADDR_W-1 -: 2] == 2'd2;
      3'd4: return a[ADDR_W-1 -: 2] == 2'd3;
      3'd5: return !a[ADDR_W-1];
      3'd6: return a[ADDR_W-1:PAGE_W] == '0;
      3'd7: return &a[ADDR_W-1:PAGE_W];
      default: return 1'b0;
    endcase
  endfunction

  logic cs_hi, cs_rise, sck_rise, sck_fall, byte_done;
  logic start_page, start_sr, wcyc_end, mem_we;

  assign cs_hi      = cs_q[1];
  assign cs_rise    = cs_q[1] & ~cs_q[2];
  assign sck_rise   = ~cs_q[1] & sck_q[1] & ~sck_q[2];
  assign sck_fall   = ~cs_q[1] & ~sck_q[1] & sck_q[2];
  assign byte_done  = sck_rise & (bitcnt == 3'd7);
  assign rx_byte    = {rx_sh, din_q[1]};
  assign status     = {busy, 2'b00, stat};
  assign waddr      = {wpage, widx};
  assign mem_we     = busy & wphase & vmask[widx] & ~locked(waddr, stat[2:0]);
  assign start_page = cs_rise & ~busy & (st == S_WR) & (bitcnt == 3'd0) & (nbytes != '0);
  assign start_sr   = cs_rise & ~busy & sr_pend & (bitcnt == 3'd0);
  assign wcyc_end   = busy & (timer == '0);
  assign miso_oe    = ~cs_hi;
  assign miso       = tx_sh[7];

  always_ff @(posedge clk or negedge rst_all_n)
    if (!rst_all_n) begin
      cs_q  <= 3'b111;
      sck_q <= 3'b000;
      din_q <= 2'b00;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      din_q <= {din_q[0], mosi};
    end

  always_ff @(posedge clk or negedge rst_all_n)
    if (!rst_all_n) begin
      st        <= S_OP;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      is_rd     <= 1'b0;
      load_pend <= 1'b0;
      wel       <= 1'b0;
      sr_pend   <= 1'b0;
      addr      <= '0;
      nbytes    <= '0;
      vmask     <= '0;
      sr_new    <= '0;
    end else begin
      if (wcyc_end) wel <= 1'b0;
      if (cs_hi) begin
        st        <= S_OP;
        bitcnt    <= '0;
        load_pend <= 1'b0;
        sr_pend   <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sh  <= rx_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (sck_fall) begin
          tx_sh     <= load_pend ? ((st == S_RS) ? status : rdata) : {tx_sh[6:0], 1'b0};
          load_pend <= 1'b0;
        end
        if (byte_done)
          case (st)
            S_OP: begin
              st <= S_SKIP;
              case (rx_byte)
                8'h06: if (!busy) wel <= 1'b1;
                8'h04: if (!busy) wel <= 1'b0;
                8'h05: begin st <= S_RS; load_pend <= 1'b1; end
                8'h03: if (!busy) begin st <= S_AH; is_rd <= 1'b1; end
                8'h02: if (!busy && wel) begin
                  st <= S_AH; is_rd <= 1'b0; nbytes <= '0; vmask <= '0;
                end
                8'h01: if (!busy && wel) st <= S_SR;
                default: ;
              endcase
            end
            S_AH: begin
              addr[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
              st <= S_AL;
            end
            S_AL: begin
              addr[7:0] <= rx_byte;
              if (is_rd) begin st <= S_RD; load_pend <= 1'b1; end
              else st <= S_WR;
            end
            S_WR: if (!nbytes[PAGE_W]) begin
              vmask[addr[PAGE_W-1:0]] <= 1'b1;
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
              nbytes <= nbytes + 1'b1;
            end
            S_RD: begin addr <= addr + 1'b1; load_pend <= 1'b1; end
            S_SR: begin sr_new <= rx_byte[4:0]; sr_pend <= 1'b1; st <= S_SKIP; end
            S_RS: load_pend <= 1'b1;
            default: ;
          endcase
      end
    end

  always_ff @(posedge clk or negedge rst_all_n)
    if (!rst_all_n) begin
      busy    <= 1'b0;
      wphase  <= 1'b0;
      kind_sr <= 1'b0;
      timer   <= '0;
      widx    <= '0;
      wpage   <= '0;
    end else if (start_page || start_sr) begin
      busy    <= 1'b1;
      wphase  <= start_page;
      kind_sr <= start_sr;
      timer   <= TW'(WRITE_CYCLES - 1);
      widx    <= '0;
      wpage   <= addr[ADDR_W-1:PAGE_W];
    end else if (busy) begin
      timer <= timer - 1'b1;
      if (wphase) begin
        widx <= widx + 1'b1;
        if (&widx) wphase <= 1'b0;
      end
      if (timer == '0) busy <= 1'b0;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) stat <= 5'b11000;
    else if (wcyc_end && kind_sr) stat <= sr_new;

  always_ff @(posedge clk)
    if (byte_done && st == S_WR && !nbytes[PAGE_W]) pbuf[addr[PAGE_W-1:0]] <= rx_byte;

  always_ff @(posedge clk) begin
    if (mem_we) mem[waddr] <= pbuf[widx];
    rdata <= mem[addr];
  end

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_all_n)
    $rose(busy) |-> wel); // R2
  AST_WEL_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_all_n)
    $fell(busy) |-> !wel); // R3
  AST_CONFIG_STEADY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_all_n)
    !busy |=> $stable(stat)); // R7
  AST_CYCLE_STARTS_DESELECTED: assert property (@(posedge clk) disable iff (!rst_all_n)
    $rose(busy) |-> cs_hi); // R10
  AST_ARRAY_WRITE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_all_n)
    mem_we |-> busy && !kind_sr); // R12
endmodule

// File: tb/spi_eeprom_ctrl_bench.sv
module spi_eeprom_ctrl_bench;
  localparam int H  = 4;
  localparam int WC = 300;

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  always #5 clk = ~clk;

  spi_eeprom_ctrl #(.WRITE_CYCLES(WC)) u_spi_eeprom_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe));

  int total = 0, bad = 0;
  logic [7:0] mem_m [1024];
  bit known [1024];
  logic [4:0] stat_m = 5'h18;
  bit wel_m = 0;
  logic [7:0] wb [20];
  logic [7:0] rb [20];
  logic [7:0] s;
  int probes [8] = '{12'h000, 12'h010, 12'h0FF, 12'h100, 12'h200, 12'h300, 12'h3EF, 12'h3F0};

  function automatic bit lk(int a, logic [2:0] b);
    case (b)
      3'd1: return a < 'h100;
      3'd2: return a >= 'h100 && a < 'h200;
      3'd3: return a >= 'h200 && a < 'h300;
      3'd4: return a >= 'h300;
      3'd5: return a < 'h200;
      3'd6: return a < 'h010;
      3'd7: return a >= 'h3F0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel; xbyte(op, d); desel;
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    sel; xbyte(8'h05, d); xbyte(8'h00, v); desel;
  endtask

  task automatic wait_idle;
    logic [7:0] v;
    for (int t = 0; t < 40; t++) begin
      rdsr(v);
      if (!v[7]) break;
    end
  endtask

  task automatic send_write(input int a, input int n);
    logic [7:0] d;
    sel; xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      wb[k] = 8'($urandom);
      xbyte(wb[k], d);
    end
    desel;
  endtask

  task automatic model_write(input int a, input int n);
    int base, ad;
    if (!wel_m || n == 0) return;
    base = a & 'h3F0;
    for (int k = 0; k < n && k < 16; k++) begin
      ad = base | ((a + k) & 'hF);
      if (!lk(ad, stat_m[2:0])) begin
        mem_m[ad] = wb[k];
        known[ad] = 1'b1;
      end
    end
    wel_m = 0;
  endtask

  task automatic do_write(input int a, input int n, input bit use_wren);
    if (use_wren) begin cmd1(8'h06); wel_m = 1; end
    send_write(a, n);
    model_write(a, n);
    wait_idle;
  endtask

  task automatic do_read_chk(input int a, input int n, input string tag);
    logic [7:0] d;
    int ad;
    sel; xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < n; k++) xbyte(8'h00, rb[k]);
    desel;
    for (int k = 0; k < n; k++) begin
      ad = (a + k) & 'h3FF;
      if (known[ad]) chk(rb[k] == mem_m[ad], tag, rb[k], mem_m[ad]);
    end
  endtask

  task automatic do_wrsr(input logic [7:0] v);
    logic [7:0] d;
    cmd1(8'h06);
    sel; xbyte(8'h01, d); xbyte(v, d); desel;
    stat_m = v[4:0];
    wel_m = 0;
    wait_idle;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog act=running exp=finished");
    finish_run;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED1));
    repeat (5) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(miso_oe == 1'b0, "R13 oe while deselected", miso_oe, 0);
    rdsr(s); chk(s == 8'h18, "R4 power-on status", s, 8'h18);

    send_write('h040, 1);
    rdsr(s); chk(s[7] == 1'b0, "R2 write without latch starts no cycle", s, 8'h18);
    sel; xbyte(8'h01, d); xbyte(8'h05, d); desel;
    rdsr(s); chk(s == 8'h18, "R2 config write without latch", s, 8'h18);

    do_write('h000, 4, 1);
    do_write('h3FC, 4, 1);
    do_read_chk('h3FE, 4, "R11 read wraps to zero");
    do_write('h10E, 4, 1);
    do_read_chk('h100, 16, "R9 page wrap");
    do_write('h120, 18, 1);
    do_read_chk('h120, 16, "R9 bytes past 16 dropped");
    do_write('hFC50, 2, 1);
    do_read_chk('hFC50, 2, "R8 upper address bits ignored");

    do_write('h030, 1, 1);
    cmd1(8'h06); wel_m = 1;
    sel; xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h30, d); xbyte(8'hA5, d);
    for (int i = 3; i >= 0; i--) begin
      mosi = 1'b1; repeat (H) @(negedge clk); sck = 1'b1; repeat (H) @(negedge clk); sck = 1'b0;
    end
    desel;
    rdsr(s); chk(s[7] == 1'b0, "R10 partial byte no cycle", s, 0);
    do_read_chk('h030, 1, "R10 partial byte leaves array");
    cmd1(8'h04); wel_m = 0;
    send_write('h030, 1); wait_idle;
    do_read_chk('h030, 1, "R1 write after disable ignored");

    do_write('h201, 1, 1);
    cmd1(8'h06); wel_m = 1;
    send_write('h200, 1); model_write('h200, 1);
    sel; xbyte(8'h05, d); xbyte(8'h00, s);
    chk(s == {3'b100, stat_m}, "R5 status during cycle", s, {3'b100, stat_m});
    xbyte(8'h00, s);
    chk(s == {3'b100, stat_m}, "R5 repeated status byte", s, {3'b100, stat_m});
    desel;
    send_write('h201, 1);
    wait_idle;
    do_read_chk('h200, 2, "R12 command during cycle ignored");
    send_write('h201, 1); wait_idle;
    do_read_chk('h201, 1, "R3 latch cleared after cycle");

    for (int b = 0; b < 8; b++) begin
      do_wrsr({3'b000, 2'b11, 3'(b)});
      rdsr(s); chk(s == {3'b000, 2'b11, 3'(b)}, "R7 config applied", s, {3'b000, 2'b11, 3'(b)});
      foreach (probes[p]) begin
        do_write(probes[p], 1, 1);
        do_read_chk(probes[p], 1, "R6 lock region");
      end
    end

    do_wrsr(8'h0D);
    cmd1(8'h06);
    @(negedge clk); rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (3) @(negedge clk);
    wel_m = 0;
    rdsr(s); chk(s == 8'h0D, "R14 config survives rst_n", s, 8'h0D);
    send_write('h300, 1); wait_idle;
    do_read_chk('h300, 1, "R3 latch cleared by reset");

    for (int it = 0; it < 20; it++) begin
      case ($urandom % 4)
        0: do_wrsr({3'b000, 5'($urandom)});
        1, 2: do_write($urandom & 'hFFFF, 1 + $urandom % 18, ($urandom % 4) != 0);
        default: do_read_chk($urandom & 'hFFFF, 1 + $urandom % 6, "R7 random read");
      endcase
    end
    do_read_chk('h3F8, 16, "R11 random sweep");

    @(negedge clk); por_n = 1'b0; repeat (3) @(negedge clk); por_n = 1'b1; repeat (3) @(negedge clk);
    rdsr(s); chk(s == 8'h18, "R14 por_n restores default", s, 8'h18);
    finish_run;
  end
endmodule